// File: doc/BRIEF.md
# Word-Serial Modular Adder

The block forms S = (A + B) mod N for wide operands, working through them one machine word at a time. The three operands live in external single-cycle-latency synchronous memories. The block drives the read addresses itself: one shared index for A and B, and a separate index for N. The result is stored into an external memory through a word address, a write strobe and a data bus. The default shape is 256-bit operands built from eight 32-bit words. It must handle the P-256 field prime as the modulus.

Words are taken least significant first. A registered carry links the word-wise additions. A registered borrow links the word-wise trial subtraction of N. Both the raw sum words and the sum-minus-N words are kept in two internal word buffers. When the last word is done, the final carry and borrow decide which buffer is copied out. A one-cycle `start` pulse launches an operation. `ready` shows when the block is idle. The memory ports are plain address and strobe ports, not streams: the memories always answer one cycle later, and the result memory always accepts a write, so no back-pressure exists.

Top module: `modadd_serial`

## Requirements
- R1: While `rst_n` is low, `ready` is 1 and `res_we` is 0.
- R2: A `start` pulse seen on a rising edge while `ready` is 1 launches an operation, and `ready` reads 0 in the following cycle.
- R3: A `start` pulse seen while `ready` is 0 is ignored. The running operation still writes exactly NUM_WORDS words and finishes on time, and no second operation follows it.
- R4: In the NUM_WORDS cycles right after the launch edge, `ab_addr` and `n_addr` both present the word indices 0, 1, … NUM_WORDS-1, one per cycle. Word index 0 is the least significant word.
- R5: If the full sum A + B, including its carry-out, is below N, the stored result equals A + B.
- R6: If the full sum A + B, including its carry-out, is at least N, the stored result equals A + B - N. This also holds when the sum overflows the operand width.
- R7: When A + B equals N exactly, the stored result is all zeros.
- R8: Results are written in NUM_WORDS consecutive cycles. `res_we` is 1 in those cycles and 0 otherwise, and `res_addr` rises from 0 by one per cycle. `ready` stays 0 while writing.
- R9: `ready` returns to 1 exactly 2*NUM_WORDS+1 cycles after the launch edge, in the cycle after the last write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle launch pulse |
| ready | output | 1 | High when idle; low while an operation runs |
| ab_addr | output | ADDR_W | Shared word index for the A and B memories |
| n_addr | output | ADDR_W | Word index for the N memory |
| a_word | input | WORD_W | A word, valid one cycle after its address |
| b_word | input | WORD_W | B word, valid one cycle after its address |
| n_word | input | WORD_W | N word, valid one cycle after its address |
| res_addr | output | ADDR_W | Result word index |
| res_we | output | 1 | Result write strobe |
| res_word | output | WORD_W | Result word data |

## Verification
The assertions assume three things: `start` is a single-cycle pulse, the operand memories return data exactly one cycle after an address, and A and B are already below N, so one subtraction is enough. The stimulus meets these conditions. The bench models the memories with a registered read. It draws random operands and reduces them modulo N before loading them. It changes memory contents only while the block is idle. Launch pulses that arrive while the block is busy are issued on purpose, both during the fetch phase and during the write phase, to check that they are ignored.

// File: rtl/modadd_pkg.sv
package modadd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_DRAIN = 2'd2,
    PH_WRITE = 2'd3
  } phase_t;
endpackage

// File: rtl/modadd_seq.sv
module modadd_seq
  import modadd_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              ready,
  output logic              clr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              take,
  output logic [ADDR_W-1:0] take_idx,
  output logic              take_last,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_WORDS - 1);

  phase_t            phase_q;
  logic [ADDR_W-1:0] rd_cnt_q;
  logic [ADDR_W-1:0] wr_cnt_q;
  logic              take_q;
  logic [ADDR_W-1:0] take_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      rd_cnt_q   <= '0;
      wr_cnt_q   <= '0;
      take_q     <= 1'b0;
      take_idx_q <= '0;
    end else begin
      take_q     <= (phase_q == PH_FETCH);
      take_idx_q <= rd_cnt_q;
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q  <= PH_FETCH;
            rd_cnt_q <= '0;
          end
        end
        PH_FETCH: begin
          if (rd_cnt_q == LAST_IDX) phase_q <= PH_DRAIN;
          else                      rd_cnt_q <= rd_cnt_q + 1'b1;
        end
        PH_DRAIN: begin
          phase_q  <= PH_WRITE;
          wr_cnt_q <= '0;
        end
        default: begin
          if (wr_cnt_q == LAST_IDX) phase_q <= PH_IDLE;
          else                      wr_cnt_q <= wr_cnt_q + 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    ready     = (phase_q == PH_IDLE);
    clr       = (phase_q == PH_IDLE) && start;
    rd_addr   = rd_cnt_q;
    take      = take_q;
    take_idx  = take_idx_q;
    take_last = take_q && (take_idx_q == LAST_IDX);
    wr_en     = (phase_q == PH_WRITE);
    wr_addr   = wr_cnt_q;
  end
endmodule

// File: rtl/modadd_slice.sv
module modadd_slice #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic [WORD_W-1:0] n,
  output logic [WORD_W-1:0] sum_o,
  output logic [WORD_W-1:0] dif_o,
  output logic              carry_o,
  output logic              borrow_o
);
  logic [WORD_W:0] s_full;
  logic [WORD_W:0] d_full;
  logic            carry_q;
  logic            borrow_q;

  always_comb begin
    s_full   = {1'b0, a} + {1'b0, b} + {{WORD_W{1'b0}}, carry_q};
    d_full   = {1'b0, s_full[WORD_W-1:0]} - {1'b0, n} - {{WORD_W{1'b0}}, borrow_q};
    sum_o    = s_full[WORD_W-1:0];
    dif_o    = d_full[WORD_W-1:0];
    carry_o  = s_full[WORD_W];
    borrow_o = d_full[WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q  <= 1'b0;
      borrow_q <= 1'b0;
    end else if (clr) begin
      carry_q  <= 1'b0;
      borrow_q <= 1'b0;
    end else if (take) begin
      carry_q  <= s_full[WORD_W];
      borrow_q <= d_full[WORD_W];
    end
  end
endmodule

// File: rtl/modadd_wordbuf.sv
module modadd_wordbuf #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem_q [NUM_WORDS];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/modadd_serial.sv
module modadd_serial #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              ready,
  output logic [ADDR_W-1:0] ab_addr,
  output logic [ADDR_W-1:0] n_addr,
  input  logic [WORD_W-1:0] a_word,
  input  logic [WORD_W-1:0] b_word,
  input  logic [WORD_W-1:0] n_word,
  output logic [ADDR_W-1:0] res_addr,
  output logic              res_we,
  output logic [WORD_W-1:0] res_word
);
  localparam int NUM_BANKS = 2;

  logic              clr, take, take_last, wr_en;
  logic [ADDR_W-1:0] rd_addr, take_idx, wr_addr;
  logic [WORD_W-1:0] sum_w, dif_w;
  logic              carry_w, borrow_w;
  logic              use_dif_q;
  logic [WORD_W-1:0] bank_wdata [NUM_BANKS];
  logic [WORD_W-1:0] bank_rdata [NUM_BANKS];

  modadd_seq #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .clr(clr),
    .rd_addr(rd_addr), .take(take), .take_idx(take_idx), .take_last(take_last),
    .wr_en(wr_en), .wr_addr(wr_addr)
  );

  modadd_slice #(.WORD_W(WORD_W)) u_slice (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take(take),
    .a(a_word), .b(b_word), .n(n_word),
    .sum_o(sum_w), .dif_o(dif_w), .carry_o(carry_w), .borrow_o(borrow_w)
  );

  assign bank_wdata[0] = sum_w;
  assign bank_wdata[1] = dif_w;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    modadd_wordbuf #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_buf (
      .clk(clk), .we(take), .waddr(take_idx), .wdata(bank_wdata[g]),
      .raddr(wr_addr), .rdata(bank_rdata[g])
    );
  end

  // Full sum >= N when it overflowed or the trial subtraction did not borrow.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         use_dif_q <= 1'b0;
    else if (take_last) use_dif_q <= carry_w | ~borrow_w;
  end

  always_comb begin
    ab_addr  = rd_addr;
    n_addr   = rd_addr;
    res_addr = wr_addr;
    res_we   = wr_en;
    res_word = use_dif_q ? bank_rdata[1] : bank_rdata[0];
  end
endmodule

// File: rtl/modadd_serial_chk.sv
module modadd_serial_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              ready,
  input logic [ADDR_W-1:0] ab_addr,
  input logic [ADDR_W-1:0] res_addr,
  input logic              res_we
);
  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready);

  p_fetch_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready) && !res_we && (ab_addr != $past(ab_addr)))
      |-> (ab_addr == $past(ab_addr) + 1'b1));

  p_write_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> !ready);

  p_write_begin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_we) |-> (res_addr == '0));

  p_write_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && $past(res_we)) |-> (res_addr == $past(res_addr) + 1'b1));

  p_done_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(res_we) |-> ready);
endmodule

bind modadd_serial modadd_serial_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
  .ab_addr(ab_addr), .res_addr(res_addr), .res_we(res_we)
);

// File: tb/modadd_serial_test.sv
module modadd_serial_test;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 8;
  localparam int ADDR_W    = 3;
  localparam int OP_W      = WORD_W * NUM_WORDS;
  localparam logic [OP_W-1:0] P256 =
    256'hffffffff00000001000000000000000000000000ffffffffffffffffffffffff;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n, start, ready, res_we;
  logic [ADDR_W-1:0] ab_addr, n_addr, res_addr;
  logic [WORD_W-1:0] a_word, b_word, n_word, res_word;

  modadd_serial #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
    .ab_addr(ab_addr), .n_addr(n_addr), .a_word(a_word), .b_word(b_word),
    .n_word(n_word), .res_addr(res_addr), .res_we(res_we), .res_word(res_word)
  );

  logic [WORD_W-1:0] mem_a [NUM_WORDS];
  logic [WORD_W-1:0] mem_b [NUM_WORDS];
  logic [WORD_W-1:0] mem_n [NUM_WORDS];
  logic [WORD_W-1:0] mem_r [NUM_WORDS];
  int wr_count;
  int wr_addr_err;
  int exp_wr_addr;

  always @(posedge clk) begin
    a_word <= mem_a[ab_addr];
    b_word <= mem_b[ab_addr];
    n_word <= mem_n[n_addr];
    if (res_we) begin
      mem_r[res_addr] <= res_word;
      wr_count <= wr_count + 1;
      if (int'(res_addr) != exp_wr_addr) wr_addr_err <= wr_addr_err + 1;
      exp_wr_addr <= exp_wr_addr + 1;
    end
  end

  int total = 0;
  int bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [OP_W-1:0] act, input logic [OP_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [OP_W-1:0] ref_sum(input logic [OP_W-1:0] a, b, n);
    logic [OP_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, n}) s = s - {1'b0, n};
    return s[OP_W-1:0];
  endfunction

  function automatic logic [OP_W-1:0] rnd_op();
    logic [OP_W-1:0] v;
    for (int i = 0; i < NUM_WORDS; i++) v[i*WORD_W +: WORD_W] = $urandom;
    return v;
  endfunction

  task automatic run_op(input logic [OP_W-1:0] a, b, n, input bit busy_pulses);
    logic [OP_W-1:0] got, exp;
    logic [OP_W:0]   full;
    int              cnt;
    int              addr_bad;
    int              wc_before;
    string           tag;
    full = {1'b0, a} + {1'b0, b};
    exp  = ref_sum(a, b, n);
    tag  = (full == {1'b0, n}) ? "R7" : ((full >= {1'b0, n}) ? "R6" : "R5");
    for (int i = 0; i < NUM_WORDS; i++) begin
      mem_a[i] = a[i*WORD_W +: WORD_W];
      mem_b[i] = b[i*WORD_W +: WORD_W];
      mem_n[i] = n[i*WORD_W +: WORD_W];
      mem_r[i] = 32'h5a5a_a5a5;
    end
    wr_count = 0; wr_addr_err = 0; exp_wr_addr = 0; addr_bad = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk);
    check(ready == 1'b0, "R2", "ready after launch", OP_W'(ready), '0);
    cnt = 0;
    while (ready == 1'b0 && cnt < 1000) begin
      cnt++;
      if (cnt <= NUM_WORDS &&
          (int'(ab_addr) != cnt - 1 || int'(n_addr) != cnt - 1)) addr_bad++;
      start = busy_pulses && (cnt == 3 || cnt == NUM_WORDS + 3);
      @(negedge clk);
    end
    start = 1'b0;
    check(cnt < 1000, "R9", "timeout", OP_W'(cnt), '0);
    check(cnt == 2*NUM_WORDS + 1, "R9", "busy length", OP_W'(cnt), OP_W'(2*NUM_WORDS + 1));
    check(addr_bad == 0, "R4", "read index sequence", OP_W'(addr_bad), '0);
    check(wr_count == NUM_WORDS, "R8", "write count", OP_W'(wr_count), OP_W'(NUM_WORDS));
    check(wr_addr_err == 0, "R8", "write order", OP_W'(wr_addr_err), '0);
    for (int i = 0; i < NUM_WORDS; i++) got[i*WORD_W +: WORD_W] = mem_r[i];
    check(got == exp, tag, "result", got, exp);
    if (busy_pulses) begin
      wc_before = wr_count;
      repeat (4) @(negedge clk);
      check(ready == 1'b1 && wr_count == wc_before, "R3", "no relaunch from busy start",
            OP_W'(wr_count), OP_W'(wc_before));
    end
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [OP_W-1:0] n2;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NUM_WORDS; i++) begin
      mem_a[i] = '0; mem_b[i] = '0; mem_n[i] = '0; mem_r[i] = '0;
    end
    wr_count = 0; wr_addr_err = 0; exp_wr_addr = 0;
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    check(ready == 1'b1, "R1", "ready in reset", OP_W'(ready), OP_W'(1));
    check(res_we == 1'b0, "R1", "res_we in reset", OP_W'(res_we), '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_op('0, '0, P256, 1'b0);
    run_op(P256 - 1, '0, P256, 1'b0);
    run_op(P256 - 1, OP_W'(1), P256, 1'b0);
    run_op(P256 - 1, P256 - 1, P256, 1'b0);
    run_op(OP_W'(5), P256 - 5, P256, 1'b1);
    for (int k = 0; k < 10; k++) begin
      run_op(rnd_op() % P256, rnd_op() % P256, P256, k == 4);
    end
    for (int k = 0; k < 6; k++) begin
      n2 = rnd_op();
      n2[OP_W-1] = (k % 2 == 0);
      n2[0] = 1'b1;
      run_op(rnd_op() % n2, rnd_op() % n2, n2, 1'b0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule